// File: doc/BRIEF.md
# Framed Manchester Line Transmitter

This block sends one parallel word per frame on a single serial line using Manchester coding. A frame starts with a calibration pulse: the line is driven high for exactly two bit periods. The pulse gives a receiver a measured reference for the bit period before any data arrives. A start bit of value 1 follows, then the data word with the least significant bit first, then a stop bit of value 0. The line is then held low for a fixed number of bit periods so that a receiver can recognise the idle state.

The bit period D is a runtime input counted in system clock cycles. Each half bit lasts D/2 cycles, so D must be even and at least 2. The period and the data word are sampled when a frame is accepted. A frame is requested with `start_i`, and it is accepted on a rising clock edge where both `start_i` and `ready_o` are high. `ready_o` stays low from that edge until the idle gap after the stop bit has fully elapsed.

Top module: `man_frame_tx`

## Requirements
- R1: After reset `ready_o` is 1 and `line_o` is 0.
- R2: A request is accepted on a rising edge where `start_i` and `ready_o` are both 1. `ready_o` is 0 from the next cycle onward, and while it is 0, `start_i` has no effect on the line waveform.
- R3: In the cycle after acceptance, `line_o` goes high and stays high for exactly 2D cycles.
- R4: The start bit follows the calibration pulse directly. It is value 1: low for D/2 cycles, then high for D/2 cycles.
- R5: Each bit occupies D cycles. A 0 is sent as high for D/2 cycles then low for D/2 cycles. A 1 is sent as low then high. Every bit therefore changes level at its midpoint.
- R6: The data field carries DATA_W bits (default 8), sent from bit 0 up to bit DATA_W-1.
- R7: After the data field comes a stop bit of value 0: high for D/2 cycles, then low for D/2 cycles.
- R8: After the stop bit, `line_o` stays low for IDLE_PERIODS*D cycles (default 5*D, which is longer than twice 2D). `ready_o` returns to 1 in the first cycle after that gap.
- R9: The data word is captured at acceptance. Changes on `data_i` during a frame do not alter the frame.
- R10: The bit period is captured at acceptance. Changes on `period_i` during a frame do not alter its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Frame request |
| data_i | input | DATA_W | Word to send |
| period_i | input | PER_W | Bit period D in clock cycles (even, at least 2) |
| ready_o | output | 1 | High when a new frame can be accepted |
| line_o | output | 1 | Serial Manchester line |

## Verification
The assertions assume that `period_i` is even and at least 2 whenever a frame is accepted. Under that assumption every half bit contains at least one half-bit tick, and every midpoint transition falls on a clock edge. The stimulus uses only even periods from 2 upward, and it changes `period_i`, `data_i` and `start_i` in the middle of a frame only after the frame's own period has been captured. The assertions also assume that reset is applied before the first request. The bench starts every run with reset asserted.

// File: rtl/mfx_pkg.sv
package mfx_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_SYNC = 2'd1,
    PH_BITS = 2'd2,
    PH_GAP  = 2'd3
  } mfx_phase_t;

  // Line level for one half of a Manchester bit: a 0 is high then low, a 1 is low then high.
  function automatic logic manch_level(input logic bit_val, input logic second_half);
    return second_half ? bit_val : ~bit_val;
  endfunction

endpackage

// File: rtl/mfx_half_timer.sv
module mfx_half_timer #(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PER_W-1:0] period,
  input  logic             run,
  output logic             tick
);

  // Half-bit length in cycles, clamped to at least one cycle.
  function automatic logic [PER_W-1:0] half_len(input logic [PER_W-1:0] d);
    logic [PER_W-1:0] h;
    h = d >> 1;
    if (h == '0) h = {{(PER_W-1){1'b0}}, 1'b1};
    return h;
  endfunction

  logic [PER_W-1:0] hl_q;
  logic [PER_W-1:0] cnt_q;

  assign tick = run && (cnt_q == hl_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hl_q  <= {{(PER_W-1){1'b0}}, 1'b1};
      cnt_q <= '0;
    end else if (load) begin
      hl_q  <= half_len(period);
      cnt_q <= '0;
    end else if (run) begin
      cnt_q <= tick ? '0 : cnt_q + 1'b1;
    end else begin
      cnt_q <= '0;
    end
  end

endmodule

// File: rtl/mfx_frame_reg.sv
module mfx_frame_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] data,
  input  logic              shift,
  output logic              cur_bit
);

  localparam int FRAME_BITS = DATA_W + 2;

  logic [FRAME_BITS-1:0] sreg_q;

  assign cur_bit = sreg_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
    end else if (load) begin
      // stop bit (0) on top, data in the middle, start bit (1) at the bottom
      sreg_q <= {1'b0, data, 1'b1};
    end else if (shift) begin
      sreg_q <= {1'b0, sreg_q[FRAME_BITS-1:1]};
    end
  end

endmodule

// File: rtl/mfx_sequencer.sv
module mfx_sequencer
  import mfx_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int IDLE_PERIODS = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       tick,
  output mfx_phase_t phase,
  output logic       accept,
  output logic       second_half,
  output logic       bit_end
);

  localparam int SYNC_HALVES = 4;
  localparam int BIT_HALVES  = 2 * (DATA_W + 2);
  localparam int GAP_HALVES  = 2 * IDLE_PERIODS;
  localparam int MAX_HALVES  = (BIT_HALVES > GAP_HALVES) ? BIT_HALVES : GAP_HALVES;
  localparam int SLOT_W      = $clog2(MAX_HALVES + 1);

  mfx_phase_t      ph_q;
  logic [SLOT_W-1:0] slot_q;

  assign phase       = ph_q;
  assign accept      = (ph_q == PH_IDLE) && start;
  assign second_half = slot_q[0];
  assign bit_end     = (ph_q == PH_BITS) && tick && slot_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      slot_q <= '0;
    end else begin
      case (ph_q)
        PH_IDLE: begin
          slot_q <= '0;
          if (start) ph_q <= PH_SYNC;
        end
        PH_SYNC: if (tick) begin
          if (slot_q == SLOT_W'(SYNC_HALVES - 1)) begin
            ph_q   <= PH_BITS;
            slot_q <= '0;
          end else begin
            slot_q <= slot_q + 1'b1;
          end
        end
        PH_BITS: if (tick) begin
          if (slot_q == SLOT_W'(BIT_HALVES - 1)) begin
            ph_q   <= PH_GAP;
            slot_q <= '0;
          end else begin
            slot_q <= slot_q + 1'b1;
          end
        end
        PH_GAP: if (tick) begin
          if (slot_q == SLOT_W'(GAP_HALVES - 1)) begin
            ph_q   <= PH_IDLE;
            slot_q <= '0;
          end else begin
            slot_q <= slot_q + 1'b1;
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/man_frame_tx.sv
module man_frame_tx
  import mfx_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int PER_W        = 16,
  parameter int IDLE_PERIODS = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [PER_W-1:0]  period_i,
  output logic              ready_o,
  output logic              line_o
);

  mfx_phase_t ev_phase;
  logic       ev_accept;
  logic       ev_half_tick;
  logic       ev_second_half;
  logic       ev_bit_end;
  logic       cur_bit;
  logic       run;

  assign run = (ev_phase != PH_IDLE);

  mfx_half_timer #(.PER_W(PER_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (ev_accept),
    .period (period_i),
    .run    (run),
    .tick   (ev_half_tick)
  );

  mfx_sequencer #(.DATA_W(DATA_W), .IDLE_PERIODS(IDLE_PERIODS)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start_i),
    .tick        (ev_half_tick),
    .phase       (ev_phase),
    .accept      (ev_accept),
    .second_half (ev_second_half),
    .bit_end     (ev_bit_end)
  );

  mfx_frame_reg #(.DATA_W(DATA_W)) u_frame (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (ev_accept),
    .data    (data_i),
    .shift   (ev_bit_end),
    .cur_bit (cur_bit)
  );

  assign ready_o = (ev_phase == PH_IDLE);

  always_comb begin
    case (ev_phase)
      PH_SYNC: line_o = 1'b1;
      PH_BITS: line_o = manch_level(cur_bit, ev_second_half);
      default: line_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/man_frame_tx_checks.sv
module man_frame_tx_checks
  import mfx_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       ready_o,
  input logic       line_o,
  input mfx_phase_t ev_phase,
  input logic       ev_half_tick,
  input logic       ev_second_half
);

  a_r1_idle_line_low: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> !line_o);

  a_r2_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && start_i) |=> !ready_o);

  a_r3_sync_high: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_phase == PH_SYNC) |-> line_o);

  a_r3_sync_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && start_i) |=> line_o);

  a_r5_mid_bit_edge: assert property (@(posedge clk) disable iff (!rst_n)
    ((ev_phase == PH_BITS) && ev_half_tick && !ev_second_half) |=> (line_o != $past(line_o)));

  a_r8_gap_low: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_phase == PH_GAP) |-> !line_o);

  a_r8_ready_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ready_o)) |-> ($past(ev_phase) == PH_GAP));

endmodule

bind man_frame_tx man_frame_tx_checks u_checks (
  .clk            (clk),
  .rst_n          (rst_n),
  .start_i        (start_i),
  .ready_o        (ready_o),
  .line_o         (line_o),
  .ev_phase       (ev_phase),
  .ev_half_tick   (ev_half_tick),
  .ev_second_half (ev_second_half)
);

// File: tb/man_frame_tx_tb.sv
module man_frame_tx_tb;

  localparam int DATA_W = 8;
  localparam int PER_W  = 16;
  localparam int IDLE_P = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_i = 1'b0;
  logic [DATA_W-1:0] data_i = '0;
  logic [PER_W-1:0]  period_i = 16'd8;
  logic              ready_o;
  logic              line_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  man_frame_tx #(.DATA_W(DATA_W), .PER_W(PER_W), .IDLE_PERIODS(IDLE_P)) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .data_i   (data_i),
    .period_i (period_i),
    .ready_o  (ready_o),
    .line_o   (line_o)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Expected line level k cycles after acceptance, derived from the frame layout.
  function automatic logic exp_line(input int k, input int d, input logic [DATA_W-1:0] w);
    int j;
    int bi;
    logic b;
    if (k < 2 * d) return 1'b1;
    j = k - 2 * d;
    if (j >= (DATA_W + 2) * d) return 1'b0;
    bi = j / d;
    if (bi == 0) b = 1'b1;
    else if (bi == DATA_W + 1) b = 1'b0;
    else b = w[bi - 1];
    if ((j % d) < d / 2) return ~b;
    return b;
  endfunction

  // Region of cycle k: 0 sync, 1 start, 2 data, 3 stop, 4 gap
  function automatic int region(input int k, input int d);
    int j;
    if (k < 2 * d) return 0;
    j = (k - 2 * d) / d;
    if (j == 0) return 1;
    if (j <= DATA_W) return 2;
    if (j == DATA_W + 1) return 3;
    return 4;
  endfunction

  task automatic t_reset_state();
    @(negedge clk);
    check("R1", "ready after reset", int'(ready_o), 1);
    check("R1", "line after reset", int'(line_o), 0);
  endtask

  // Sends one frame; when disturb is set, inputs are changed in mid-frame.
  task automatic t_frame(input logic [DATA_W-1:0] w, input int d, input bit disturb);
    int total;
    int bad[5];
    int rdy_bad;
    total = (2 + DATA_W + 2 + IDLE_P) * d;
    for (int i = 0; i < 5; i++) bad[i] = 0;
    rdy_bad = 0;
    while (!ready_o) @(negedge clk);
    data_i   = w;
    period_i = PER_W'(d);
    start_i  = 1'b1;
    @(posedge clk);
    for (int k = 0; k <= total; k++) begin
      @(negedge clk);
      if (k == 0) start_i = 1'b0;
      if (disturb && k == 5) begin
        data_i   = ~w;
        period_i = PER_W'(d + 6);
        start_i  = 1'b1;
      end
      if (disturb && k == total - 3) start_i = 1'b0;
      if (k < total) begin
        if (line_o !== exp_line(k, d, w)) bad[region(k, d)]++;
        if (ready_o !== 1'b0) rdy_bad++;
      end else begin
        check("R8", "line low at frame end", int'(line_o), 0);
        check("R8", "ready returns after gap", int'(ready_o), 1);
      end
    end
    check("R3", "sync pulse mismatches", bad[0], 0);
    check("R4", "start bit mismatches", bad[1], 0);
    check(disturb ? "R9" : "R6", "data field mismatches (R5 encoding)", bad[2], 0);
    check("R7", "stop bit mismatches", bad[3], 0);
    check(disturb ? "R10" : "R8", "gap mismatches", bad[4], 0);
    check("R2", "ready high while busy", rdy_bad, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_frame(8'hA5, 8, 1'b0);   // R5 R6 mixed pattern
    t_frame(8'h01, 2, 1'b0);   // smallest period
    t_frame(8'hFF, 10, 1'b0);  // all ones
    t_frame(8'h00, 4, 1'b0);   // all zeros
    t_frame(8'h3C, 12, 1'b1);  // R2 R9 R10 mid-frame disturbance
    t_frame(8'h96, 6, 1'b0);   // back to back after disturbance
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule